// File: doc/BRIEF.md
# SPI Interrupt Status and Mask Bank

This block is the interrupt register bank of an SPI master. It sits on a simple 32-bit register bus with a write strobe, an address and write data, and it returns read data combinationally for the address presented. The SPI datapath supplies four raw event inputs: a mode-fault pulse, a transmit-queue-above-threshold pulse, a transmit-queue-full pulse and a receive-queue-has-data level. The bank captures the three pulsed events as sticky status bits. It passes the receive level straight through as a live status bit, and it drives one registered interrupt line.

Software enables sources by writing ones to a set-only address and disables them by writing ones to a clear-only address. It reads the resulting enables at a separate read-only address. It acknowledges events by writing back the status bits it read, because a one clears a bit and a zero leaves it alone. Seven bits are implemented in every register and the rest read as zero.

Top module: `spi_irq_bank`

## Requirements
- R1: After reset the status register, the enable mask and `irq_o` are all zero.
- R2: A one-cycle pulse on `evt_modf`, `evt_txow` or `evt_txfull` sets status bit 1, 2 or 3 respectively. The bit stays set after the pulse ends.
- R3: A write to address 0x04 clears each status bit whose write-data bit is 1. Bits written 0 keep their value.
- R4: A write to address 0x08 sets each mask bit (bits 6..0) whose write-data bit is 1. Zero bits leave the mask unchanged.
- R5: A write to address 0x0C clears each mask bit whose write-data bit is 1, and writing 0x7F clears the whole mask. Zero bits leave the mask unchanged.
- R6: Status bit 4 reads as the present level of `evt_rxne` in the same cycle, and a write of 1 to it at 0x04 has no effect.
- R7: `irq_o` is a register loaded each cycle with the OR over all bits of (status AND mask). It follows a change in either by one clock.
- R8: When a source event and a write-one-to-clear hit the same status bit in the same cycle, the bit stays set.
- R9: Address 0x10 reads the mask, and writes to it have no effect. Reads of 0x00, 0x08 and 0x0C return zero, and read-data bits 31..7 are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_modf | input | 1 | Mode-fault event pulse |
| evt_txow | input | 1 | Transmit queue above threshold pulse |
| evt_txfull | input | 1 | Transmit queue full pulse |
| evt_rxne | input | 1 | Receive queue not empty level |
| irq_o | output | 1 | Combined registered interrupt |

## Verification
Mask writes use patterns with mixed ones and zeros, an all-zero write and the 0x7F write. These separate true set and clear behaviour from a plain register store. Status clears use partial, zero and full write-back patterns, which show that only the written-one bits drop. A clear that coincides with a fresh event exposes the wrong priority. Toggling the receive level while writing its bit shows that the bit is live and not latched, and sampling `irq_o` on both sides of each mask and status change pins down its one-cycle lag.

// File: rtl/spi_irq_bank.sv
module spi_irq_bank #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int NBITS  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              evt_modf,
  input  logic              evt_txow,
  input  logic              evt_txfull,
  input  logic              evt_rxne,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(8'h10);
  localparam int B_MODF = 1, B_TXOW = 2, B_TXFULL = 3, B_RXNE = 4;

  logic [NBITS-1:0] sticky, mask, raw, live, view, wd;
  logic             unused_hi;

  assign wd        = bus_wdata[NBITS-1:0];
  assign unused_hi = ^bus_wdata[DATA_W-1:NBITS];

  always_comb begin
    raw = '0;
    raw[B_MODF]   = evt_modf;
    raw[B_TXOW]   = evt_txow;
    raw[B_TXFULL] = evt_txfull;
    live = '0;
    live[B_RXNE]  = evt_rxne;
  end

  assign view = sticky | live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky <= '0;
      mask   <= '0;
      irq_o  <= 1'b0;
    end else begin
      sticky <= (sticky & ~((bus_we && bus_addr == A_STAT) ? wd : '0)) | raw;
      if (bus_we && bus_addr == A_SET)      mask <= mask | wd;
      else if (bus_we && bus_addr == A_CLR) mask <= mask & ~wd;
      irq_o <= |(view & mask);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_STAT)      bus_rdata[NBITS-1:0] = view;
    else if (bus_addr == A_MASK) bus_rdata[NBITS-1:0] = mask;
  end
endmodule

module spi_irq_bank_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int NBITS  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              evt_modf,
  input logic              evt_rxne,
  input logic              irq_o,
  input logic [NBITS-1:0]  sticky,
  input logic [NBITS-1:0]  mask
);
  AST_MODF_WINS: assert property (@(posedge clk) disable iff (!rst_n) evt_modf |=> sticky[1]); // R8
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky[1] && !(bus_we && bus_addr == ADDR_W'(8'h04) && bus_wdata[1])) |=> sticky[1]); // R2
  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(8'h08)) |=> ((mask & $past(bus_wdata[NBITS-1:0])) == $past(bus_wdata[NBITS-1:0]))); // R4
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(8'h0C)) |=> ((mask & $past(bus_wdata[NBITS-1:0])) == '0)); // R5
  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sticky & mask)) |=> irq_o); // R7
  AST_RXNE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(8'h04)) |-> (bus_rdata[4] == evt_rxne)); // R6
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:NBITS] == '0); // R9
endmodule

bind spi_irq_bank spi_irq_bank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NBITS(NBITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .evt_modf(evt_modf), .evt_rxne(evt_rxne), .irq_o(irq_o),
  .sticky(sticky), .mask(mask));

// File: tb/tb_spi_irq_bank.sv
module tb_spi_irq_bank;
  logic        clk = 0, rst_n = 0, bus_we = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        evt_modf = 0, evt_txow = 0, evt_txfull = 0, evt_rxne = 0, irq_o;
  int nchk = 0, nfail = 0;
  bit done = 0;

  spi_irq_bank dut (.*);

  always #4 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0; bus_wdata = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h04, d); chk("R1 status", d, 0);
    rd(8'h10, d); chk("R1 mask", d, 0);
    chk("R1 irq", irq_o, 0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(8'h08, 32'h06); rd(8'h10, d); chk("R4 set", d, 32'h06);
    wr(8'h08, 32'h00); rd(8'h10, d); chk("R4 zero write", d, 32'h06);
    wr(8'h08, 32'hFFFF_FF10); rd(8'h10, d); chk("R4 set more", d, 32'h16);
    wr(8'h0C, 32'h04); rd(8'h10, d); chk("R5 clear", d, 32'h12);
    wr(8'h0C, 32'h00); rd(8'h10, d); chk("R5 zero write", d, 32'h12);
    rd(8'h08, d); chk("R9 set addr reads 0", d, 0);
    rd(8'h0C, d); chk("R9 clr addr reads 0", d, 0);
    rd(8'h00, d); chk("R9 addr 0 reads 0", d, 0);
    wr(8'h10, 32'h7F); rd(8'h10, d); chk("R9 mask addr write ignored", d, 32'h12);
    wr(8'h0C, 32'h7F); rd(8'h10, d); chk("R5 clear all", d, 0);
  endtask

  task automatic pulse(int which);
    @(negedge clk);
    case (which) 1: evt_modf = 1; 2: evt_txow = 1; default: evt_txfull = 1; endcase
    @(negedge clk);
    evt_modf = 0; evt_txow = 0; evt_txfull = 0;
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    pulse(1); rd(8'h04, d); chk("R2 modf", d, 32'h02);
    pulse(3); rd(8'h04, d); chk("R2 txfull", d, 32'h0A);
    cyc(); chk("R7 masked no irq", irq_o, 0);
    wr(8'h08, 32'h02); chk("R7 irq lags mask", irq_o, 0);
    cyc(); chk("R7 irq asserted", irq_o, 1);
    wr(8'h04, 32'h08); rd(8'h04, d); chk("R3 partial clear", d, 32'h02);
    wr(8'h04, 32'h00); rd(8'h04, d); chk("R3 zero write", d, 32'h02);
    wr(8'h04, 32'h02); rd(8'h04, d); chk("R3 clear last", d, 0);
    chk("R7 irq still old", irq_o, 1);
    cyc(); chk("R7 irq drops", irq_o, 0);
    wr(8'h0C, 32'h7F);
  endtask

  task automatic t_race();
    logic [31:0] d;
    pulse(2); rd(8'h04, d); chk("R2 txow", d, 32'h04);
    @(negedge clk); bus_we = 1; bus_addr = 8'h04; bus_wdata = 32'h04; evt_txow = 1;
    @(negedge clk); bus_we = 0; bus_wdata = 0; evt_txow = 0;
    rd(8'h04, d); chk("R8 event beats clear", d, 32'h04);
    wr(8'h04, 32'h7F); rd(8'h04, d); chk("R3 full clear", d, 0);
  endtask

  task automatic t_rxne();
    logic [31:0] d;
    @(negedge clk); evt_rxne = 1;
    rd(8'h04, d); chk("R6 live high", d, 32'h10);
    wr(8'h04, 32'h10); rd(8'h04, d); chk("R6 clear ignored", d, 32'h10);
    wr(8'h08, 32'h10); chk("R7 rx irq lags", irq_o, 0);
    cyc(); chk("R7 rx irq", irq_o, 1);
    evt_rxne = 0; rd(8'h04, d); chk("R6 live low", d, 0);
    cyc(); chk("R7 rx irq drops", irq_o, 0);
  endtask

  initial begin
    #1 t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_mask();
    t_sticky();
    t_race();
    t_rxne();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule